// File: doc/BRIEF.md
# Daisy-Chain Serial Result Output

This block is the digital read-out side of one 14-bit sampling converter that can sit in a daisy chain of identical converters. It watches a convert strobe, a serial clock and a serial input. It starts a conversion through a stub converter core and parks the finished result in a shift register. From there the result is clocked out MSB first on the serial output. The serial input feeds the tail of the register, so the words of the converters upstream follow this device's own word out of the same pin.

A rising convert strobe while the serial clock is low selects chain operation and requests a conversion. The strobe stays high through the conversion and the read-out. When the core signals completion, the MSB appears on the serial output at once, with no clock edge needed, and the power-down indication rises. Each later falling serial clock edge shifts the register one place and captures the serial input. A falling convert strobe ends the transfer and returns the interface to idle.

The convert strobe, serial clock and serial input are asynchronous. They pass through two-stage synchronizers into the system clock domain, and edges are detected on the synchronized values.

Top module: `chain_sdo_top`

## Requirements
- R1: While the convert strobe is low (idle), `sdo_out` is 0, and `pwr_dn` is 0.
- R2: A rising `cnv_in` while `sck_in` is low raises `conv_start` for exactly one system clock cycle and begins a conversion.
- R3: A rising `cnv_in` while `sck_in` is high starts no conversion: `conv_start` stays 0 and a later `core_done` leaves `sdo_out` at 0.
- R4: Falling `sck_in` edges that occur during the conversion do not shift the register; after completion the full word still comes out from its MSB.
- R5: The cycle after `core_done` is seen during a conversion, `sdo_out` equals bit 13 of `core_data` and `pwr_dn` is 1, with no serial clock edge.
- R6: After the k-th falling `sck_in` edge of the read-out (k = 1..13), `sdo_out` equals bit 13-k of the loaded result.
- R7: Each falling `sck_in` edge captures `sdi_in` into bit 0 of the register. After 14 + j falling edges (j = 0..13), `sdo_out` equals the `sdi_in` value captured at falling edge j + 1.
- R8: A falling `cnv_in` during the read-out returns to idle: `sdo_out` and `pwr_dn` go to 0, and later serial clock edges or `core_done` pulses leave them at 0.
- R9: A falling `cnv_in` during the conversion aborts it, and a `core_done` that arrives afterwards leaves `sdo_out` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv_in | input | 1 | Convert strobe, asynchronous |
| sck_in | input | 1 | Serial clock, asynchronous |
| sdi_in | input | 1 | Serial data from the upstream device, asynchronous |
| core_done | input | 1 | One-cycle completion strobe from the converter core |
| core_data | input | 14 | Conversion result, valid with `core_done` |
| conv_start | output | 1 | One-cycle request to the core to start converting |
| pwr_dn | output | 1 | High while the result is held for read-out (acquisition and power-down) |
| sdo_out | output | 1 | Serial data out, MSB first |

## Verification
The assertions assume that `sck_in` and `sdi_in` each stay stable for at least the synchronizer depth plus one system clock around every transition. They also assume that `core_done` is a single-cycle pulse. The bench holds every serial clock level and every data bit for four system clocks, and changes `sdi_in` only while `sck_in` is high. Its core stub produces exactly one done pulse a fixed number of cycles after `conv_start`. Because of this, each edge the block detects corresponds to exactly one edge the bench drove.

// File: rtl/chain_sdo_pkg.sv
// Shared types for the chain-mode serial output interface.
package chain_sdo_pkg;
    // Interface phases: waiting for a start, converting, holding data for read-out.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_READ = 2'd2
    } phase_t;
endpackage

// File: rtl/chain_sdo_sync.sv
// Multi-stage synchronizer for a vector of asynchronous single-bit inputs.
// Assumes each input bit is independent; no multi-bit coherence is provided.
module chain_sdo_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stg [STAGES];

    // Shift the raw inputs through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/chain_sdo_ctrl.sv
// Phase controller: detects edges on the synchronized strobe and clock,
// selects chain operation, and issues load and shift commands.
// Assumes its inputs are already in the clk domain.
module chain_sdo_ctrl
    import chain_sdo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cnv_s,
    input  logic   sck_s,
    input  logic   core_done,
    output phase_t phase,
    output logic   conv_start,
    output logic   load,
    output logic   shift_en,
    output logic   sck_fall
);
    logic   cnv_d, sck_d;
    logic   cnv_rise, cnv_fall;
    phase_t phase_nx;

    // Keep one-cycle-old copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_d <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cnv_d <= cnv_s;
            sck_d <= sck_s;
        end
    end

    assign cnv_rise = cnv_s & ~cnv_d;
    assign cnv_fall = ~cnv_s & cnv_d;
    assign sck_fall = ~sck_s & sck_d;

    // Next phase; a falling strobe takes priority over everything else.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: if (cnv_rise && !sck_s) phase_nx = PH_CONV;
            PH_CONV: if (cnv_fall) phase_nx = PH_IDLE;
                     else if (core_done) phase_nx = PH_READ;
            PH_READ: if (cnv_fall) phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    assign load     = (phase == PH_CONV) && core_done && !cnv_fall;
    assign shift_en = (phase == PH_READ) && sck_fall && !cnv_fall;

    // Phase register and the one-cycle start request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            conv_start <= 1'b0;
        end else begin
            phase      <= phase_nx;
            conv_start <= (phase == PH_IDLE) && (phase_nx == PH_CONV);
        end
    end

    // R2: a start request is only ever issued after a low serial clock.
    a_r2_start_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(sck_s));
    // R2: the start request lasts exactly one cycle.
    a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R9: a conversion always follows a strobe that is still high.
    a_r9_conv_needs_cnv: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV) |-> $past(cnv_s));
endmodule

// File: rtl/chain_sdo_shreg.sv
// Result shift register: parallel load from the core, serial shift toward
// the MSB with the serial input entering at bit 0.
// Assumes load and shift are never requested in the same cycle.
module chain_sdo_shreg #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    input  logic              ser_in,
    output logic              msb
);
    localparam int TOP = DATA_W - 1;

    logic [DATA_W-1:0] shreg;

    // Load the new result or move every bit one place toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (load)     shreg <= load_data;
        else if (shift_en) shreg <= {shreg[TOP-1:0], ser_in};
    end

    assign msb = shreg[TOP];

    // R5: the MSB presented after a load is the core's MSB.
    a_r5_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> msb == $past(load_data[TOP]));
    // R6: after a shift the new MSB is the old next bit.
    a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_en) && !$past(load)) |-> msb == $past(shreg[TOP-1]));
    // R7: the serial input lands in the vacated tail bit.
    a_r7_tail_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(shift_en) && !$past(load)) |-> shreg[0] == $past(ser_in));
endmodule

// File: rtl/chain_sdo_top.sv
// Chain-mode serial result output for one converter in a daisy chain.
// Assumes cnv_in, sck_in and sdi_in are asynchronous to clk, and that the
// core raises core_done for one cycle with the result on core_data.
module chain_sdo_top
    import chain_sdo_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_data,
    output logic              conv_start,
    output logic              pwr_dn,
    output logic              sdo_out
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw_v, sync_v;
    logic   cnv_s, sck_s, sdi_s;
    phase_t phase;
    logic   load, shift_en, sck_fall, msb;

    assign raw_v = {cnv_in, sck_in, sdi_in};
    assign {cnv_s, sck_s, sdi_s} = sync_v;

    chain_sdo_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_v), .d_sync(sync_v)
    );

    chain_sdo_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cnv_s(cnv_s), .sck_s(sck_s),
        .core_done(core_done), .phase(phase), .conv_start(conv_start),
        .load(load), .shift_en(shift_en), .sck_fall(sck_fall)
    );

    chain_sdo_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(core_data),
        .shift_en(shift_en), .ser_in(sdi_s), .msb(msb)
    );

    assign sdo_out = (phase == PH_READ) ? msb : 1'b0;
    assign pwr_dn  = (phase == PH_READ);

    // R1: with the strobe low for two samples the output is held low.
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnv_s && !$past(cnv_s)) |-> (!sdo_out && !pwr_dn));
    // R4: a serial clock edge during the conversion does not shift.
    a_r4_no_shift_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && sck_fall) |-> !shift_en);
    // R8: a falling strobe during read-out leads back to idle.
    a_r8_fall_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && !cnv_s && $past(cnv_s)) |=> !pwr_dn);
endmodule

// File: tb/chain_sdo_top_tb_top.sv
// Directed bench for the chain-mode serial output interface.
module chain_sdo_top_tb_top;
    localparam int DW       = 14;
    localparam int CONV_CYC = 12;
    localparam int HOLD     = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnv_in = 1'b0, sck_in = 1'b0, sdi_in = 1'b0;
    logic          core_done = 1'b0;
    logic [DW-1:0] core_data = '0;
    logic          conv_start, pwr_dn, sdo_out;

    int errs = 0, checks = 0;
    bit finished = 0;
    bit start_seen;
    int start_count;

    always #5 clk = ~clk;

    chain_sdo_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnv_in(cnv_in), .sck_in(sck_in),
        .sdi_in(sdi_in), .core_done(core_done), .core_data(core_data),
        .conv_start(conv_start), .pwr_dn(pwr_dn), .sdo_out(sdo_out)
    );

    // Count start-request cycles, sampled away from the edge.
    always @(negedge clk) if (conv_start) start_count++;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full serial clock period ending on a falling edge; SDI changes while SCK is high.
    task automatic sck_pulse(input logic din);
        sck_in = 1'b1; wait_cyc(1); sdi_in = din; wait_cyc(HOLD);
        sck_in = 1'b0; wait_cyc(HOLD);
    endtask

    // Core stub: done pulse a fixed number of cycles after the start request.
    task automatic core_respond(input logic [DW-1:0] val, output bit got);
        got = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (conv_start) got = 1;
        end
        if (got) begin
            wait_cyc(CONV_CYC);
            core_data = val; core_done = 1'b1;
            wait_cyc(1); core_done = 1'b0;
        end
    endtask

    task automatic end_frame();
        cnv_in = 1'b0; wait_cyc(HOLD + 2);
    endtask

    task automatic t_reset();
        chk("R1 reset sdo", sdo_out, 1'b0);
        chk("R1 reset pwr_dn", pwr_dn, 1'b0);
        sdi_in = 1'b1; wait_cyc(HOLD);
        chk("R1 idle sdo with sdi high", sdo_out, 1'b0);
        sdi_in = 1'b0;
    endtask

    task automatic t_single(input logic [DW-1:0] val);
        bit got;
        start_count = 0;
        cnv_in = 1'b1;
        core_respond(val, got);
        chk("R2 start seen", got, 1'b1);
        chk("R2 start one cycle", start_count == 1, 1'b1);
        wait_cyc(1);
        chk("R5 msb without sck", sdo_out, val[DW-1]);
        chk("R5 pwr_dn", pwr_dn, 1'b1);
        for (int k = 1; k < DW; k++) begin
            sck_pulse(1'b0);
            chk("R6 shifted bit", sdo_out, val[DW-1-k]);
        end
        end_frame();
        chk("R8 sdo idle after fall", sdo_out, 1'b0);
        chk("R8 pwr_dn idle after fall", pwr_dn, 1'b0);
        sck_pulse(1'b1);
        chk("R8 sck ignored in idle", sdo_out, 1'b0);
        core_data = '1; core_done = 1'b1; wait_cyc(1); core_done = 1'b0; wait_cyc(2);
        chk("R8 done ignored in idle", sdo_out, 1'b0);
    endtask

    task automatic t_chain(input logic [DW-1:0] own, input logic [DW-1:0] up);
        bit got;
        cnv_in = 1'b1;
        fork
            core_respond(own, got);
            begin
                // R4: serial clock toggling while the conversion runs.
                wait_cyc(HOLD + 4);
                sck_pulse(1'b1);
            end
        join
        wait_cyc(1);
        chk("R4 msb intact after busy sck", sdo_out, own[DW-1]);
        for (int k = 1; k <= 2 * DW; k++) begin
            sck_pulse(k <= DW ? up[DW-k] : 1'b0);
            if (k < DW)
                chk("R4 R6 own bit", sdo_out, own[DW-1-k]);
            else if (k < 2 * DW)
                chk("R7 upstream bit", sdo_out, up[DW-1-(k-DW)]);
        end
        end_frame();
    endtask

    task automatic t_sck_high_start();
        bit got;
        start_count = 0;
        sck_in = 1'b1; wait_cyc(HOLD);
        cnv_in = 1'b1; wait_cyc(HOLD);
        sck_in = 1'b0; wait_cyc(HOLD);
        chk("R3 no start with sck high", start_count == 0, 1'b1);
        core_data = '1; core_done = 1'b1; wait_cyc(1); core_done = 1'b0; wait_cyc(2);
        chk("R3 sdo stays low", sdo_out, 1'b0);
        chk("R3 pwr_dn stays low", pwr_dn, 1'b0);
        end_frame();
        got = 0;
    endtask

    task automatic t_abort();
        cnv_in = 1'b1; wait_cyc(HOLD + 2);
        cnv_in = 1'b0; wait_cyc(HOLD);
        core_data = '1; core_done = 1'b1; wait_cyc(1); core_done = 1'b0; wait_cyc(2);
        chk("R9 done after abort ignored", sdo_out, 1'b0);
        chk("R9 pwr_dn after abort", pwr_dn, 1'b0);
        wait_cyc(HOLD);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(HOLD);
        t_reset();
        t_single(14'h2A5C);
        t_single(14'h3FFF);
        t_chain(14'h1234, 14'h0B6D);
        t_sck_high_start();
        t_abort();
        t_single(14'h2001);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule